// File: doc/BRIEF.md
# FIFO Port Width Adapter with Selectable Byte Order

This block sits on both ports of a FIFO core whose storage word is 36 bits. On the write side it collects 9-bit or 18-bit transfers into a full storage word and hands that word to storage once it is complete. On the read side it takes a full storage word from the head of storage and hands it out as a series of 18-bit or 9-bit transfers. It pops the next storage word only after the last piece of the current one has gone out. Each side runs on its own clock.

A static configuration sets the pairing of port widths and the byte order. The byte order decides which lane is filled or emitted first: the most significant lane or the least significant lane. The configuration is sampled while reset is applied and on the first clock edge after release. After that it does not change. Reset also discards any partly assembled word and returns both lane counters to the first lane.

Top module: `fwa_width_adapter`

## Requirements
- R1: After reset `st_wvalid_o`, `st_rd_o` and `rd_valid_o` are 0 and both data outputs are 0. A reset taken in the middle of a word discards the lanes already collected, so the next complete word contains only lanes written after the reset.
- R2: `cfg_mode_i` and `cfg_big_endian_i` are sampled while `rst_ni` is low and on the first rising edge after release. Later changes to them have no effect until the next reset.
- R3: With a full-width write side, each cycle with `wr_en_i` high produces `st_wvalid_o`=1 in the next cycle, with `st_wdata_o` equal to the `wr_data_i` that was accepted.
- R4: Mode code 4 (9 in, 36 out) with `cfg_big_endian_i`=1 places the first accepted byte (`wr_data_i[8:0]`) in bits 35:27. The second goes in bits 26:18, the third in bits 17:9 and the fourth in bits 8:0.
- R5: Mode code 4 with `cfg_big_endian_i`=0 places the first accepted byte in bits 8:0. The second goes in 17:9, the third in 26:18 and the fourth in 35:27.
- R6: Mode code 3 (18 in, 36 out) takes `wr_data_i[17:0]` per transfer. The first half goes to bits 35:18 in big-endian order and to bits 17:0 in little-endian order. The second half fills the other half.
- R7: `st_wvalid_o` is a single-cycle pulse in the cycle after the last lane of a word is accepted. It stays 0 after earlier lanes. Cycles with `wr_en_i` low do not advance the lane count, whether the enables are back to back or have gaps.
- R8: Mode code 2 (36 in, 9 out) emits the four bytes of `st_rdata_i` in `rd_data_o[8:0]`, with bits 35:9 of `rd_data_o` at 0. Big-endian order starts at bits 35:27 and little-endian order starts at bits 8:0.
- R9: Mode code 1 (36 in, 18 out) emits two halves in `rd_data_o[17:0]`, with upper bits 0. Big-endian order gives bits 35:18 first and little-endian order gives bits 17:0 first.
- R10: `st_rd_o` is high, combinationally, only in a cycle where `rd_en_i` is high and the current lane is the last one of the word. `rd_valid_o` and `rd_data_o` update one cycle after each accepted `rd_en_i`.
- R11: With a full-width read side, every accepted `rd_en_i` pops storage and returns the whole of `st_rdata_i` one cycle later.
- R12: Mode code 0 selects 36 in and 36 out. Codes 5 to 7 behave as code 0 on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both sides |
| cfg_mode_i | input | 3 | Width pairing code, sampled at reset |
| cfg_big_endian_i | input | 1 | 1: most significant lane first; 0: least significant first |
| wr_en_i | input | 1 | Write transfer accepted this cycle |
| wr_data_i | input | 36 | Write data; narrow modes use the low bits |
| st_wvalid_o | output | 1 | Complete word presented to storage |
| st_wdata_o | output | 36 | Assembled storage word |
| rd_en_i | input | 1 | Read transfer accepted this cycle |
| st_rdata_i | input | 36 | Head word of storage |
| st_rd_o | output | 1 | Pop head word from storage |
| rd_valid_o | output | 1 | Read data updated this cycle |
| rd_data_o | output | 36 | Read data; narrow modes use the low bits |

## Verification
A lane counter that is off by one shows up on the write side as a `st_wvalid_o` pulse one lane early or late, with bytes rotated in the assembled word. That is visible within one word of the fault. On the read side the same fault shows as an `st_rd_o` pop in the wrong cycle and a wrong byte on the next `rd_data_o`. A reversed or lost endian setting swaps lanes in the very first word. A configuration that is not held after reset changes the packing in the first word written after `cfg_mode_i` moves. The tests therefore compare every lane, the exact pop cycle and the exact valid pulse cycle for both byte orders and every pairing.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef enum logic [2:0] {
    MODE_36_36 = 3'd0,
    MODE_36_18 = 3'd1,
    MODE_36_9  = 3'd2,
    MODE_18_36 = 3'd3,
    MODE_9_36  = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    LW_FULL = 2'd0,
    LW_HALF = 2'd1,
    LW_BYTE = 2'd2
  } lane_w_e;

  function automatic lane_w_e wr_lane_w(input logic [2:0] mode);
    case (mode)
      MODE_18_36: return LW_HALF;
      MODE_9_36:  return LW_BYTE;
      default:    return LW_FULL;
    endcase
  endfunction

  function automatic lane_w_e rd_lane_w(input logic [2:0] mode);
    case (mode)
      MODE_36_18: return LW_HALF;
      MODE_36_9:  return LW_BYTE;
      default:    return LW_FULL;
    endcase
  endfunction

endpackage

// File: rtl/fwa_cfg_sample.sv
module fwa_cfg_sample #(
  parameter int MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              be_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              be_o,
  output logic              open_o
);

  logic              open_q;
  logic [MODE_W-1:0] mode_q;
  logic              be_q;

  // window stays open through reset and the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b1;
    else         open_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (open_q) begin
      mode_q <= mode_i;
      be_q   <= be_i;
    end
  end

  assign mode_o = mode_q;
  assign be_o   = be_q;
  assign open_o = open_q;

endmodule

// File: rtl/fwa_packer.sv
module fwa_packer
  import fwa_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  lane_w_e                     lane_w_i,
  input  logic                        be_i,
  input  logic                        wr_en_i,
  input  logic [BYTE_W*LANES-1:0]     wr_data_i,
  output logic                        word_valid_o,
  output logic [BYTE_W*LANES-1:0]     word_o
);

  localparam int WORD_W = BYTE_W * LANES;
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = (LANES > 2) ? $clog2(LANES) : 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  bpos;
  logic              hpos;
  logic              is_last;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] merged;

  always_comb begin
    case (lane_w_i)
      LW_BYTE: last_idx = CNT_W'(LANES - 1);
      LW_HALF: last_idx = CNT_W'(1);
      default: last_idx = '0;
    endcase
  end

  assign is_last = (cnt_q == last_idx);
  assign bpos    = be_i ? (CNT_W'(LANES - 1) - cnt_q) : cnt_q;
  assign hpos    = be_i ? ~cnt_q[0] : cnt_q[0];

  always_comb begin
    merged = acc_q;
    case (lane_w_i)
      LW_BYTE: begin
        for (int i = 0; i < LANES; i++) begin
          if (CNT_W'(i) == bpos) merged[i*BYTE_W +: BYTE_W] = wr_data_i[BYTE_W-1:0];
        end
      end
      LW_HALF: begin
        if (hpos) merged[HALF_W +: HALF_W] = wr_data_i[HALF_W-1:0];
        else      merged[0 +: HALF_W]      = wr_data_i[HALF_W-1:0];
      end
      default: merged = wr_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      acc_q        <= '0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (wr_en_i) begin
        if (is_last) begin
          word_o       <= merged;
          word_valid_o <= 1'b1;
          acc_q        <= '0;
          cnt_q        <= '0;
        end else begin
          acc_q <= merged;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fwa_unpacker.sv
module fwa_unpacker
  import fwa_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  lane_w_e                 lane_w_i,
  input  logic                    be_i,
  input  logic                    rd_en_i,
  input  logic [BYTE_W*LANES-1:0] word_i,
  output logic                    fetch_o,
  output logic                    valid_o,
  output logic [BYTE_W*LANES-1:0] data_o
);

  localparam int WORD_W = BYTE_W * LANES;
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = (LANES > 2) ? $clog2(LANES) : 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  bpos;
  logic              hpos;
  logic              is_last;
  logic [WORD_W-1:0] lane_sel;

  always_comb begin
    case (lane_w_i)
      LW_BYTE: last_idx = CNT_W'(LANES - 1);
      LW_HALF: last_idx = CNT_W'(1);
      default: last_idx = '0;
    endcase
  end

  assign is_last = (cnt_q == last_idx);
  assign bpos    = be_i ? (CNT_W'(LANES - 1) - cnt_q) : cnt_q;
  assign hpos    = be_i ? ~cnt_q[0] : cnt_q[0];
  assign fetch_o = rd_en_i && is_last;

  always_comb begin
    lane_sel = '0;
    case (lane_w_i)
      LW_BYTE: begin
        for (int i = 0; i < LANES; i++) begin
          if (CNT_W'(i) == bpos) lane_sel[BYTE_W-1:0] = word_i[i*BYTE_W +: BYTE_W];
        end
      end
      LW_HALF: begin
        lane_sel[HALF_W-1:0] = hpos ? word_i[HALF_W +: HALF_W] : word_i[0 +: HALF_W];
      end
      default: lane_sel = word_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= rd_en_i;
      if (rd_en_i) begin
        data_o <= lane_sel;
        cnt_q  <= is_last ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/fwa_width_adapter.sv
module fwa_width_adapter
  import fwa_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int LANES  = 4,
  parameter int MODE_W = 3,
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_big_endian_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              st_wvalid_o,
  output logic [WORD_W-1:0] st_wdata_o,
  input  logic              rd_en_i,
  input  logic [WORD_W-1:0] st_rdata_i,
  output logic              st_rd_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [MODE_W-1:0] wr_mode, rd_mode;
  logic              wr_be, rd_be;
  logic              wr_cfg_open, rd_cfg_open;
  lane_w_e           wr_lw, rd_lw;

  fwa_cfg_sample #(.MODE_W(MODE_W)) u_wr_cfg (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .mode_i (cfg_mode_i),
    .be_i   (cfg_big_endian_i),
    .mode_o (wr_mode),
    .be_o   (wr_be),
    .open_o (wr_cfg_open)
  );

  fwa_cfg_sample #(.MODE_W(MODE_W)) u_rd_cfg (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .mode_i (cfg_mode_i),
    .be_i   (cfg_big_endian_i),
    .mode_o (rd_mode),
    .be_o   (rd_be),
    .open_o (rd_cfg_open)
  );

  assign wr_lw = wr_lane_w(3'(wr_mode));
  assign rd_lw = rd_lane_w(3'(rd_mode));

  fwa_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_packer (
    .clk_i        (wr_clk_i),
    .rst_ni       (rst_ni),
    .lane_w_i     (wr_lw),
    .be_i         (wr_be),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .word_valid_o (st_wvalid_o),
    .word_o       (st_wdata_o)
  );

  fwa_unpacker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_unpacker (
    .clk_i    (rd_clk_i),
    .rst_ni   (rst_ni),
    .lane_w_i (rd_lw),
    .be_i     (rd_be),
    .rd_en_i  (rd_en_i),
    .word_i   (st_rdata_i),
    .fetch_o  (st_rd_o),
    .valid_o  (rd_valid_o),
    .data_o   (rd_data_o)
  );

endmodule

// File: rtl/fwa_checker.sv
module fwa_checker
  import fwa_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int LANES  = 4,
  parameter int MODE_W = 3,
  localparam int WORD_W = BYTE_W * LANES
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              st_wvalid_o,
  input logic [WORD_W-1:0] st_wdata_o,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] st_rdata_i,
  input logic              st_rd_o,
  input logic              rd_valid_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [MODE_W-1:0] wr_mode,
  input logic [MODE_W-1:0] rd_mode,
  input logic              wr_be,
  input logic              rd_be,
  input logic              wr_cfg_open,
  input logic              rd_cfg_open
);

  logic wr_full, wr_narrow, rd_full, rd_byte;
  assign wr_full   = (wr_lane_w(3'(wr_mode)) == LW_FULL);
  assign wr_narrow = !wr_full;
  assign rd_full   = (rd_lane_w(3'(rd_mode)) == LW_FULL);
  assign rd_byte   = (rd_lane_w(3'(rd_mode)) == LW_BYTE);

  // R2 configuration frozen once the sample window has closed
  a_r2_wr_cfg_hold: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (!wr_cfg_open && !$past(wr_cfg_open)) |-> ($stable(wr_mode) && $stable(wr_be)));
  a_r2_rd_cfg_hold: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (!rd_cfg_open && !$past(rd_cfg_open)) |-> ($stable(rd_mode) && $stable(rd_be)));

  // R3 full-width write passes data through one cycle later
  a_r3_wr_pass: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_full && wr_en_i) |=> (st_wvalid_o && st_wdata_o == $past(wr_data_i)));

  // R7 word pulse only after an accepted transfer, never two in a row when narrow
  a_r7_wvalid_after_accept: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    st_wvalid_o |-> $past(wr_en_i));
  a_r7_narrow_single_pulse: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_narrow && st_wvalid_o) |=> !st_wvalid_o);

  // R8 narrow byte output keeps upper bits clear
  a_r8_upper_zero: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_byte && rd_valid_o) |-> (rd_data_o[WORD_W-1:BYTE_W] == '0));

  // R10 pop only on an accepted read; data follows each accepted read
  a_r10_pop_needs_en: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    st_rd_o |-> rd_en_i);
  a_r10_rvalid_follows: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o == $past(rd_en_i));

  // R11 full-width read pops every transfer and returns the head word
  a_r11_rd_pass: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_full && rd_en_i) |-> st_rd_o);
  a_r11_rd_data: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_full && rd_en_i) |=> (rd_data_o == $past(st_rdata_i)));

endmodule

bind fwa_width_adapter fwa_checker #(
  .BYTE_W (BYTE_W),
  .LANES  (LANES),
  .MODE_W (MODE_W)
) u_fwa_checker (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .st_wvalid_o (st_wvalid_o),
  .st_wdata_o  (st_wdata_o),
  .rd_en_i     (rd_en_i),
  .st_rdata_i  (st_rdata_i),
  .st_rd_o     (st_rd_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .wr_mode     (wr_mode),
  .rd_mode     (rd_mode),
  .wr_be       (wr_be),
  .rd_be       (rd_be),
  .wr_cfg_open (wr_cfg_open),
  .rd_cfg_open (rd_cfg_open)
);

// File: tb/fwa_width_adapter_tb.sv
`timescale 1ns/1ps
module fwa_width_adapter_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_be = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        st_wvalid;
  logic [35:0] st_wdata;
  logic        rd_en = 1'b0;
  logic [35:0] st_rdata = '0;
  logic        st_rd;
  logic        rd_valid;
  logic [35:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fwa_width_adapter u_dut (
    .wr_clk_i         (clk),
    .rd_clk_i         (clk),
    .rst_ni           (rst_ni),
    .cfg_mode_i       (cfg_mode),
    .cfg_big_endian_i (cfg_be),
    .wr_en_i          (wr_en),
    .wr_data_i        (wr_data),
    .st_wvalid_o      (st_wvalid),
    .st_wdata_o       (st_wdata),
    .rd_en_i          (rd_en),
    .st_rdata_i       (st_rdata),
    .st_rd_o          (st_rd),
    .rd_valid_o       (rd_valid),
    .rd_data_o        (rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] mode, input logic be);
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    cfg_mode = mode; cfg_be = be;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one write transfer with a gap after it; check pulse and word
  task automatic wr_lane(input logic [35:0] d, input bit exp_v, input logic [35:0] exp_w, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(st_wvalid == exp_v, req, 36'(st_wvalid), 36'(exp_v));
    if (exp_v) chk(st_wdata == exp_w, req, st_wdata, exp_w);
  endtask

  // one read transfer; check pop in the same cycle, data next cycle
  task automatic rd_lane(input logic [35:0] exp_d, input bit exp_pop, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    #1;
    chk(st_rd == exp_pop, {req, " pop"}, 36'(st_rd), 36'(exp_pop));
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, {req, " valid"}, 36'(rd_valid), 36'd1);
    chk(rd_data == exp_d, {req, " data"}, rd_data, exp_d);
  endtask

  function automatic logic [8:0] byte_of(input logic [35:0] w, input int k, input bit be);
    int idx = be ? 3 - k : k;
    return w[idx*9 +: 9];
  endfunction

  task automatic t_reset_state;
    do_reset(3'd4, 1'b1);
    chk(st_wvalid == 1'b0, "R1 wvalid", 36'(st_wvalid), 36'd0);
    chk(st_rd == 1'b0, "R1 pop", 36'(st_rd), 36'd0);
    chk(rd_valid == 1'b0, "R1 rvalid", 36'(rd_valid), 36'd0);
    chk(st_wdata == '0 && rd_data == '0, "R1 data", st_wdata | rd_data, 36'd0);
  endtask

  task automatic t_pass(input logic [2:0] mode, input string req);
    do_reset(mode, 1'b1);
    wr_lane(36'h9_8765_4321, 1'b1, 36'h9_8765_4321, req);
    wr_lane(36'h1_2345_6789, 1'b1, 36'h1_2345_6789, req);
    st_rdata = 36'hA_BCDE_F012;
    rd_lane(36'hA_BCDE_F012, 1'b1, {req, " R11"});
    st_rdata = 36'h5_5AA5_5AA5;
    rd_lane(36'h5_5AA5_5AA5, 1'b1, {req, " R11"});
  endtask

  task automatic t_wr_byte(input bit be, input string req);
    logic [8:0]  b[4] = '{9'h1A5, 9'h03C, 9'h1FF, 9'h042};
    logic [35:0] exp = be ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
    do_reset(3'd4, be);
    for (int k = 0; k < 4; k++)
      wr_lane({27'h7FFFFFF, b[k]}, k == 3, exp, {req, " R7"});
  endtask

  task automatic t_wr_half(input bit be);
    logic [17:0] h0 = 18'h2_ABCD;
    logic [17:0] h1 = 18'h1_1234;
    do_reset(3'd3, be);
    wr_lane({18'h3_FFFF, h0}, 1'b0, '0, "R6 first half");
    wr_lane({18'h3_FFFF, h1}, 1'b1, be ? {h0, h1} : {h1, h0}, "R6 word");
  endtask

  task automatic t_wr_b2b;
    int pulses = 0;
    do_reset(3'd4, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (st_wvalid) pulses++;
      wr_en = 1'b1; wr_data = 36'(k + 1);
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (st_wvalid) pulses++;
    chk(st_wvalid && st_wdata == {9'd8, 9'd7, 9'd6, 9'd5}, "R7 back-to-back word", st_wdata, {9'd8, 9'd7, 9'd6, 9'd5});
    chk(pulses == 2, "R7 pulse count", 36'(pulses), 36'd2);
  endtask

  task automatic t_rd_byte(input bit be, input string req);
    logic [35:0] w0 = 36'hC_3A5F_0E71;
    logic [35:0] w1 = 36'h2_468A_CE13;
    do_reset(3'd2, be);
    st_rdata = w0;
    for (int k = 0; k < 4; k++) rd_lane({27'd0, byte_of(w0, k, be)}, k == 3, {req, " R10"});
    st_rdata = w1;
    rd_lane({27'd0, byte_of(w1, 0, be)}, 1'b0, {req, " R10 next word"});
  endtask

  task automatic t_rd_half(input bit be);
    logic [35:0] w = 36'hF_0123_4567;
    do_reset(3'd1, be);
    st_rdata = w;
    rd_lane({18'd0, be ? w[35:18] : w[17:0]}, 1'b0, "R9 first half");
    rd_lane({18'd0, be ? w[17:0] : w[35:18]}, 1'b1, "R9 second half");
  endtask

  task automatic t_cfg_ignore;
    do_reset(3'd4, 1'b1);
    cfg_mode = 3'd0; cfg_be = 1'b0;
    wr_lane(36'h011, 1'b0, '0, "R2 mode held lane0");
    wr_lane(36'h022, 1'b0, '0, "R2 mode held lane1");
    wr_lane(36'h033, 1'b0, '0, "R2 mode held lane2");
    wr_lane(36'h044, 1'b1, {9'h011, 9'h022, 9'h033, 9'h044}, "R2 order held");
  endtask

  task automatic t_reset_mid;
    do_reset(3'd4, 1'b0);
    wr_lane(36'h1EE, 1'b0, '0, "R1 pre-reset lane");
    wr_lane(36'h1DD, 1'b0, '0, "R1 pre-reset lane");
    do_reset(3'd4, 1'b0);
    wr_lane(36'h001, 1'b0, '0, "R1 post-reset lane");
    wr_lane(36'h002, 1'b0, '0, "R1 post-reset lane");
    wr_lane(36'h003, 1'b0, '0, "R1 post-reset lane");
    wr_lane(36'h004, 1'b1, {9'h004, 9'h003, 9'h002, 9'h001}, "R1 clean word");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_pass(3'd0, "R12 code0 R3");
    t_pass(3'd6, "R12 code6 R3");
    t_wr_byte(1'b1, "R4");
    t_wr_byte(1'b0, "R5");
    t_wr_half(1'b1);
    t_wr_half(1'b0);
    t_wr_b2b();
    t_rd_byte(1'b1, "R8 big");
    t_rd_byte(1'b0, "R8 little");
    t_rd_half(1'b1);
    t_rd_half(1'b0);
    t_cfg_ignore();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule